// File: doc/BRIEF.md
# Random-Delay Transmit Scheduler

This block sets the moment at which a passive identification tag sends its code. A bit-rate tick is derived from the free-running oscillator by a divider that a configuration field selects. On each tick a delay counter steps forward. A transmission is requested when the counter agrees with a pseudo-random number over a configurable count of low bits. On that match the random generator takes one step and the counter restarts from zero, so the next wait is fresh. The count of compared bits sets the longest possible wait. Code 0 compares no bits, so the tag sends again as soon as the previous code is finished.

The scheduler also unpacks the 16-bit configuration word. It acts on the reader's commands as they arrive from a gap detector outside the block. An acknowledge either stops all further transmissions or slows the counter to one step in sixteen ticks. A mute freezes the counter for as long as it is held. The encoder and gap detector that sit beside this block read the decoded option bits at the block's outputs.

Top module: `txdly_sched`

## Requirements
- R1: While reset is low, tx_start and bit_tick are low. In the first cycle after reset is released, the random generator is loaded from `seed`.
- R2: The rate code sits in cfg_word bits 8:6. bit_tick is high for one oscillator cycle in every 2^(code+1) cycles, so code 0 gives a divide by 2 and code 7 a divide by 256.
- R3: The delay code sits in cfg_word bits 5:3. Codes 1 to 7 compare the low 4, 6, 8, 10, 12, 14 or 16 bits. Code 0 compares no bits, so a start follows at the first bit tick after the previous transmission completes.
- R4: At each counter advance the current count is compared with the random value. On agreement tx_start pulses for one cycle, the counter returns to 0 and the generator steps. Otherwise the counter increments. The generator shifts left and feeds bit 0 with the XOR of bits 15, 13, 12 and 10.
- R5: When cfg_word bit 2 is 0, an effective ack_rcvd puts the block into slow-down for the rest of the run. In slow-down the counter advances only on every sixteenth bit tick.
- R6: When cfg_word bit 2 is 1, an effective ack_rcvd stops all further tx_start pulses until reset.
- R7: mute takes effect only when cfg_word bit 0 is 1 and bit 1 is 0. While it is in effect the counter holds its value and no transmission starts. With bit 0 at 0, mute has no effect on the starts.
- R8: When cfg_word bit 1 is 1, ack_rcvd and mute are both ignored.
- R9: cfg_fast, cfg_free_run, cfg_switch_off, cfg_manchester and cfg_hf_gap present cfg_word bits 0, 1, 2, 9 and 10.
- R10: An all-zero seed is replaced by 16'hACE1.
- R11: After a tx_start pulse, no new start occurs until tx_done has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 16 | Configuration word |
| seed | input | 16 | Random generator seed |
| tx_done | input | 1 | Strobe: current code fully sent |
| ack_rcvd | input | 1 | Strobe: acknowledge detected |
| mute | input | 1 | Level: mute in force |
| tx_start | output | 1 | One-cycle transmission request |
| bit_tick | output | 1 | Bit-rate tick |
| cfg_fast | output | 1 | Fast mode option |
| cfg_free_run | output | 1 | Gap detection disabled |
| cfg_switch_off | output | 1 | Ack switches off (else slows down) |
| cfg_manchester | output | 1 | Manchester encoding selected |
| cfg_hf_gap | output | 1 | High-frequency gap detection selected |

## Verification
The hardest state to reach from the ports is slow-down with the prescaler in phase against a masked match. Every start then depends on sixteen ticks, on the random value and on the exact moment the acknowledge landed. The stimulus uses the fastest rate and a 4-bit compare, so that dozens of slowed starts fit into a short run. It sends one acknowledge while the counter is in the middle of a wait. A behavioural model then predicts every tick and every start cycle. The zero-seed case is confirmed separately: the cycle of the first start is computed by hand from the replacement value.

// File: rtl/txs_pkg.sv
package txs_pkg;

   // Decoded option fields; packed so that bit 0 of the struct is bit 0 of the word
   typedef struct packed {
      logic       hf_gap;    // bit 10
      logic       manch;     // bit 9
      logic [2:0] rate;      // bits 8:6
      logic [2:0] dly;       // bits 5:3
      logic       sw_off;    // bit 2
      logic       free_run;  // bit 1
      logic       fast;      // bit 0
   } cfg_t;

   localparam int CFG_USED_W = $bits(cfg_t);

   typedef enum logic [1:0] {
      ST_BOOT = 2'd0,
      ST_RUN  = 2'd1,
      ST_TXW  = 2'd2,
      ST_OFF  = 2'd3
   } sch_st_t;

   localparam logic [15:0] LFSR_TAPS_16 = 16'hB400;  // x^16+x^14+x^13+x^11+1
   localparam logic [15:0] SEED_FIX_16  = 16'hACE1;

endpackage

// File: rtl/txs_cfg_decode.sv
module txs_cfg_decode
   import txs_pkg::*;
(
   input  logic [CFG_USED_W-1:0] word_lo,
   output cfg_t                  cfg
);

   assign cfg = cfg_t'(word_lo);

endmodule

// File: rtl/txs_rate_div.sv
module txs_rate_div #(
   parameter int DIV_BASE = 2,
   parameter int RATE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              bit_tick
);

   localparam int N_RATES = 1 << RATE_W;
   localparam int MAX_DIV = DIV_BASE << (N_RATES - 1);
   localparam int DW      = $clog2(MAX_DIV);

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] lim_tab [N_RATES];
   logic [DW-1:0] lim;

   // One terminal count per rate code, each doubling the previous divisor
   for (genvar r = 0; r < N_RATES; r++) begin : g_lim
      assign lim_tab[r] = DW'((DIV_BASE << r) - 1);
   end

   assign lim      = lim_tab[rate];
   assign bit_tick = (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bit_tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);  // R2

endmodule

// File: rtl/txs_lfsr.sv
module txs_lfsr #(
   parameter int           W    = 16,
   parameter logic [W-1:0] TAPS = W'(16'hB400),
   parameter logic [W-1:0] ZFIX = W'(16'hACE1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   output logic [W-1:0] q
);

   logic fb;

   assign fb = ^(q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= ZFIX;
      end else if (load) begin
         q <= (seed == '0) ? ZFIX : seed;
      end else if (step) begin
         q <= {q[W-2:0], fb};
      end
   end

   AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);  // R10

endmodule

// File: rtl/txs_delay_match.sv
module txs_delay_match #(
   parameter int CNT_W    = 16,
   parameter int SLOW_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic             slow,
   input  logic [2:0]       dly_code,
   input  logic [CNT_W-1:0] rnd,
   output logic             hit,
   output logic [CNT_W-1:0] dcnt
);

   logic             adv;
   logic [CNT_W-1:0] mask;

   // Compare width: none for code 0, else 2*code+2 low bits (clipped to CNT_W)
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask[i] = (dly_code != 3'd0) && (i < (2 * int'(dly_code) + 2));
   end

   if (SLOW_LOG > 0) begin : g_pre
      logic [SLOW_LOG-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (tick_in && slow) begin
            pre_q <= pre_q + 1'b1;
         end
      end
      assign adv = tick_in && (!slow || (pre_q == '1));
   end else begin : g_nopre
      assign adv = tick_in;
   end

   assign hit = adv && (((dcnt ^ rnd) & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt <= '0;
      end else if (hit) begin
         dcnt <= '0;
      end else if (adv) begin
         dcnt <= dcnt + 1'b1;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_in |=> $stable(dcnt));  // R4

endmodule

// File: rtl/txdly_sched.sv
module txdly_sched
   import txs_pkg::*;
#(
   parameter int               CNT_W     = 16,
   parameter logic [CNT_W-1:0] LFSR_TAPS = CNT_W'(LFSR_TAPS_16),
   parameter logic [CNT_W-1:0] SEED_FIX  = CNT_W'(SEED_FIX_16),
   parameter int               DIV_BASE  = 2,
   parameter int               SLOW_LOG  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      cfg_word,
   input  logic [CNT_W-1:0] seed,
   input  logic             tx_done,
   input  logic             ack_rcvd,
   input  logic             mute,
   output logic             tx_start,
   output logic             bit_tick,
   output logic             cfg_fast,
   output logic             cfg_free_run,
   output logic             cfg_switch_off,
   output logic             cfg_manchester,
   output logic             cfg_hf_gap
);

   cfg_t             cfg;
   sch_st_t          st_q;
   logic             slow_q;
   logic             mute_eff;
   logic             ack_eff;
   logic             kill;
   logic             adv_tick;
   logic             hit;
   logic [CNT_W-1:0] rnd;
   logic [CNT_W-1:0] dcnt;
   logic             cfg_unused;

   assign cfg_unused = ^cfg_word[15:CFG_USED_W];

   txs_cfg_decode i_dec (
      .word_lo (cfg_word[CFG_USED_W-1:0]),
      .cfg     (cfg)
   );

   assign cfg_fast       = cfg.fast;
   assign cfg_free_run   = cfg.free_run;
   assign cfg_switch_off = cfg.sw_off;
   assign cfg_manchester = cfg.manch;
   assign cfg_hf_gap     = cfg.hf_gap;

   txs_rate_div #(
      .DIV_BASE (DIV_BASE),
      .RATE_W   (3)
   ) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate     (cfg.rate),
      .bit_tick (bit_tick)
   );

   // Reader commands only count when gap detection is enabled
   assign mute_eff = mute && cfg.fast && !cfg.free_run;
   assign ack_eff  = ack_rcvd && !cfg.free_run && (st_q != ST_BOOT);
   assign kill     = ack_eff && cfg.sw_off;
   assign adv_tick = bit_tick && (st_q == ST_RUN) && !mute_eff;

   txs_delay_match #(
      .CNT_W    (CNT_W),
      .SLOW_LOG (SLOW_LOG)
   ) i_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (adv_tick),
      .slow     (slow_q),
      .dly_code (cfg.dly),
      .rnd      (rnd),
      .hit      (hit),
      .dcnt     (dcnt)
   );

   txs_lfsr #(
      .W    (CNT_W),
      .TAPS (LFSR_TAPS),
      .ZFIX (SEED_FIX)
   ) i_rnd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st_q == ST_BOOT),
      .step  ((st_q == ST_RUN) && hit && !kill),
      .seed  (seed),
      .q     (rnd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_BOOT;
         slow_q   <= 1'b0;
         tx_start <= 1'b0;
      end else begin
         tx_start <= 1'b0;
         if (kill) begin
            st_q <= ST_OFF;
         end else begin
            unique case (st_q)
               ST_BOOT: st_q <= ST_RUN;
               ST_RUN: begin
                  if (hit) begin
                     st_q     <= ST_TXW;
                     tx_start <= 1'b1;
                  end
               end
               ST_TXW: begin
                  if (tx_done) st_q <= ST_RUN;
               end
               default: st_q <= ST_OFF;
            endcase
         end
         if (ack_eff && !cfg.sw_off) slow_q <= 1'b1;
      end
   end

   AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);  // R11
   AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (dcnt == '0));  // R4
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OFF) |-> !tx_start);  // R6
   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && mute_eff) |=> $stable(dcnt));  // R7

endmodule

// File: tb/test_txdly_sched.sv
module test_txdly_sched;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [15:0] seed = 16'h1234;
   logic        tx_done = 1'b0;
   logic        ack_rcvd = 1'b0;
   logic        mute = 1'b0;
   logic        tx_start, bit_tick;
   logic        cfg_fast, cfg_free_run, cfg_switch_off, cfg_manchester, cfg_hf_gap;

   int n_chk = 0, n_bad = 0;
   int m_div, m_st, m_dcnt, m_pre, m_lfsr, m_slow, m_txs;
   int resp = 0, resp_en = 1;
   int n_starts, m_starts, n_ticks, cyc_n, first_start;

   always #(CLK_PERIOD / 2) clk = ~clk;

   txdly_sched i_txdly_sched (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_word       (cfg_word),
      .seed           (seed),
      .tx_done        (tx_done),
      .ack_rcvd       (ack_rcvd),
      .mute           (mute),
      .tx_start       (tx_start),
      .bit_tick       (bit_tick),
      .cfg_fast       (cfg_fast),
      .cfg_free_run   (cfg_free_run),
      .cfg_switch_off (cfg_switch_off),
      .cfg_manchester (cfg_manchester),
      .cfg_hf_gap     (cfg_hf_gap)
   );

   function automatic logic [15:0] mk(int fast, int fr, int so, int dly, int rate, int man, int hf);
      return 16'((fast & 1) | ((fr & 1) << 1) | ((so & 1) << 2) | ((dly & 7) << 3)
                 | ((rate & 7) << 6) | ((man & 1) << 9) | ((hf & 1) << 10));
   endfunction

   function automatic int lim_of(int r);
      return (2 << r) - 1;
   endfunction

   function automatic int mask_of(int c);
      if (c == 0) return 0;
      return (1 << (2 * c + 2)) - 1;
   endfunction

   function automatic int rnd_next(int x);
      int fb;
      fb = ((x >> 15) ^ (x >> 13) ^ (x >> 12) ^ (x >> 10)) & 1;
      return ((x << 1) & 16'hFFFF) | fb;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_div = 0; m_st = 0; m_dcnt = 0; m_pre = 0;
      m_lfsr = 16'hACE1; m_slow = 0; m_txs = 0;
   endtask

   task automatic model_step();
      int  dly    = int'(cfg_word[5:3]);
      int  rate   = int'(cfg_word[8:6]);
      bit  fast   = cfg_word[0];
      bit  fr     = cfg_word[1];
      bit  so     = cfg_word[2];
      bit  tick   = (m_div >= lim_of(rate));
      bit  mute_e = mute && fast && !fr;
      bit  ack_e  = ack_rcvd && !fr && (m_st != 0);
      bit  kill   = ack_e && so;
      bit  advt   = tick && (m_st == 1) && !mute_e;
      bit  adv    = advt && (!m_slow || m_pre == 15);
      bit  hit    = adv && (((m_dcnt ^ m_lfsr) & mask_of(dly)) == 0);
      int  nst    = m_st;
      m_txs = 0;
      m_div = tick ? 0 : m_div + 1;
      if (advt && m_slow) m_pre = (m_pre + 1) % 16;
      if (hit) m_dcnt = 0;
      else if (adv) m_dcnt = (m_dcnt + 1) % 65536;
      if (m_st == 0) m_lfsr = (seed == 0) ? 16'hACE1 : int'(seed);
      else if (m_st == 1 && hit && !kill) m_lfsr = rnd_next(m_lfsr);
      if (kill) nst = 3;
      else if (m_st == 0) nst = 1;
      else if (m_st == 1 && hit) begin nst = 2; m_txs = 1; end
      else if (m_st == 2 && tx_done) nst = 1;
      m_st = nst;
      if (ack_e && !so) m_slow = 1;
   endtask

   task automatic cyc();
      @(posedge clk);
      if (!rst_n) model_reset(); else model_step();
      @(negedge clk);
      cyc_n++;
      chk(bit_tick === (m_div >= lim_of(int'(cfg_word[8:6]))), "R2", "bit_tick",
          int'(bit_tick), int'(m_div >= lim_of(int'(cfg_word[8:6]))));
      chk(tx_start === m_txs[0], "R4", "tx_start", int'(tx_start), m_txs);
      if (tx_start) begin
         n_starts++;
         if (first_start < 0) first_start = cyc_n;
      end
      if (bit_tick) n_ticks++;
      if (m_txs != 0) m_starts++;
      tx_done = 1'b0;
      if (resp_en != 0 && tx_start) resp = 3;
      else if (resp > 0) begin
         resp--;
         if (resp == 0) tx_done = 1'b1;
      end
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic clear_cnt();
      n_starts = 0; m_starts = 0; n_ticks = 0; cyc_n = 0; first_start = -1;
   endtask

   task automatic do_reset(logic [15:0] cw, logic [15:0] sd);
      rst_n = 1'b0; cfg_word = cw; seed = sd; mute = 1'b0; ack_rcvd = 1'b0;
      resp = 0; tx_done = 1'b0;
      run(3);
      chk(tx_start === 1'b0, "R1", "tx_start in reset", int'(tx_start), 0);
      chk(bit_tick === 1'b0, "R1", "bit_tick in reset", int'(bit_tick), 0);
      rst_n = 1'b1;
      clear_cnt();
   endtask

   task automatic pulse_ack();
      ack_rcvd = 1'b1;
      cyc();
      ack_rcvd = 1'b0;
   endtask

   initial begin
      // R4: basic masked-compare scheduling
      do_reset(mk(0, 0, 0, 1, 0, 0, 0), 16'h1234);
      run(3000);
      chk(n_starts > 0, "R4", "starts in window", n_starts, 1);
      chk(n_starts == m_starts, "R4", "start count", n_starts, m_starts);

      // R9: option fields
      cfg_word = mk(1, 0, 1, 2, 1, 1, 1);
      run(2);
      chk({cfg_hf_gap, cfg_manchester, cfg_switch_off, cfg_free_run, cfg_fast} === 5'b11101,
          "R9", "fields A", int'({cfg_hf_gap, cfg_manchester, cfg_switch_off, cfg_free_run, cfg_fast}), 29);
      cfg_word = mk(0, 1, 0, 2, 1, 0, 0);
      run(2);
      chk({cfg_hf_gap, cfg_manchester, cfg_switch_off, cfg_free_run, cfg_fast} === 5'b00010,
          "R9", "fields B", int'({cfg_hf_gap, cfg_manchester, cfg_switch_off, cfg_free_run, cfg_fast}), 2);

      // R2: divide by 16 at rate code 3
      do_reset(mk(0, 0, 0, 1, 3, 0, 0), 16'h4321);
      run(40);
      n_ticks = 0;
      run(512);
      chk(n_ticks == 32, "R2", "ticks in 512 cycles", n_ticks, 32);

      // R3: continuous retransmission
      do_reset(mk(0, 0, 0, 0, 0, 0, 0), 16'h0F0F);
      run(300);
      chk(n_starts >= 40, "R3", "back-to-back starts", n_starts, 40);

      // R5: slow-down after acknowledge
      do_reset(mk(0, 0, 0, 1, 0, 0, 0), 16'h1234);
      run(21);
      pulse_ack();
      clear_cnt();
      run(5000);
      chk(n_starts > 0, "R5", "slowed starts present", n_starts, 1);
      chk(n_starts <= 157, "R5", "slowed start ceiling", n_starts, 157);
      chk(n_starts == m_starts, "R5", "slowed start count", n_starts, m_starts);

      // R6: switch-off after acknowledge
      do_reset(mk(0, 0, 1, 1, 0, 0, 0), 16'h1234);
      run(50);
      pulse_ack();
      clear_cnt();
      run(3000);
      chk(n_starts == 0, "R6", "starts after switch-off", n_starts, 0);

      // R7: mute pauses in fast mode only
      do_reset(mk(1, 0, 0, 1, 0, 0, 0), 16'h2222);
      run(50);
      mute = 1'b1;
      run(5);
      clear_cnt();
      run(2000);
      chk(n_starts == 0, "R7", "starts while muted", n_starts, 0);
      mute = 1'b0;
      clear_cnt();
      run(2000);
      chk(n_starts > 0, "R7", "starts after unmute", n_starts, 1);
      cfg_word = mk(0, 0, 0, 1, 0, 0, 0);
      mute = 1'b1;
      clear_cnt();
      run(2000);
      chk(n_starts > 0, "R7", "mute without fast mode", n_starts, 1);
      mute = 1'b0;

      // R8: free-running ignores ack and mute
      do_reset(mk(1, 1, 1, 1, 0, 0, 0), 16'h3333);
      run(30);
      pulse_ack();
      mute = 1'b1;
      clear_cnt();
      run(3000);
      chk(n_starts > 0, "R8", "free-running starts", n_starts, 1);
      mute = 1'b0;

      // R10: zero seed -> 16'hACE1, low 10 bits 225 -> first start at cycle 452
      do_reset(mk(0, 0, 0, 4, 0, 0, 0), 16'h0000);
      run(600);
      chk(first_start == 452, "R10", "first start cycle", first_start, 452);

      // R11: no second start without tx_done
      resp_en = 0;
      do_reset(mk(0, 0, 0, 0, 0, 0, 0), 16'h5555);
      run(500);
      chk(n_starts == 1, "R11", "starts without tx_done", n_starts, 1);
      resp_en = 1;

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule